// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

The block records a stream of already-packed trace words into an on-chip RAM used as a ring. While capture is enabled, each word arriving with its valid strobe goes through a single-entry holding register and is then written at the write pointer. The write pointer wraps at the end of the RAM, and a sticky flag records that the ring has wrapped at least once. A trigger flag travels with each word. Once a triggered word has been stored, a software-loaded counter counts the words stored after it. When the counter runs out, acquisition is complete and the ring stops accepting data. The capture window can therefore be placed anywhere around the trigger event.

Software reaches the block through a simple register port: address, write data, write enable, read enable and read data. Through it software sets up the pointers and the counter, enables capture, polls status, and finally reads the trace back through a RAM data register that advances the read pointer on every read. When the wrap flag is set, the oldest word sits at the write pointer. Otherwise the valid words occupy slots 0 up to the write pointer minus one. The RAM depth must be a power of two of at least 2, and the word width must be at most 32 bits.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0x8, both pointers read 0 and the trigger counter reads 0.
- R2: Register addresses are: 0 control, 1 status, 2 write pointer, 3 read pointer, 4 RAM data, 5 trigger counter, 6 depth, 7 width. Control bit 0 is the capture enable and control bit 1 is the port-mode select, which is stored and read back. A read returns its data on reg_rdata_o in the cycle after the clock edge that samples reg_re_i.
- R3: Each stored word is written at the write pointer, and the pointer then advances by one, wrapping from DEPTH-1 to 0. The wrap sets status bit 0 (Full), which stays set.
- R4: Storing a word whose trigger flag is set sets status bit 1 (Triggered), which stays set.
- R5: Each word stored while Triggered is already set decrements the trigger counter. The trigger word itself does not decrement it. The word that brings the counter to 0 sets status bit 2 (AcquisitionComplete). A count of 0 behaves like a count of 1.
- R6: While AcquisitionComplete is set, arriving words are not stored and the write pointer does not move.
- R7: Software writes to the write pointer, the read pointer (low log2(DEPTH) bits) and the trigger counter (all 32 bits) read back as written.
- R8: A read of the RAM data register returns RAM[read pointer]. The same read advances the read pointer by one, wrapping from DEPTH-1 to 0.
- R9: Status bit 3 (FormatterEmpty) is 0 exactly when a word is pending in the holding register, which is in the cycle after the word is accepted. Otherwise it reads 1.
- R10: A control write that changes the enable from 0 to 1 clears status bits 0 to 2. A control write with bit 0 set while capture is already enabled clears none of them.
- R11: Clearing the enable stops storing words but keeps the pointers, the trigger counter and the status flags unchanged.
- R12: The depth register reads DEPTH and the width register reads WIDTH. Writes to addresses 1, 4, 6 and 7 have no effect.
- R13: A word is accepted only while capture is enabled and acquisition is not complete. An accepted word is written to RAM at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_valid_i | input | 1 | Packed trace word valid strobe |
| trace_word_i | input | WIDTH | Packed trace word |
| trace_trig_i | input | 1 | Trigger flag for this word |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write enable |
| reg_re_i | input | 1 | Register read enable |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after the read |

## Verification
A word driven with trace_valid_i is taken into the holding register at the first edge and written to RAM at the second. Its effect on the pointer and the flags can therefore be seen only by a register read sampled at the third edge or later. FormatterEmpty is the one exception: it is checked by a status read issued in the cycle right after acceptance. Register reads are sampled at the falling edge after the rising edge that takes reg_re_i. The bench drives every input at falling edges and starts each new operation no earlier than one full cycle after the previous one, so every result is due before it is sampled.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] A_WPTR  = 3'd2;
  localparam logic [REG_AW-1:0] A_RPTR  = 3'd3;
  localparam logic [REG_AW-1:0] A_RDATA = 3'd4;
  localparam logic [REG_AW-1:0] A_TCNT  = 3'd5;
  localparam logic [REG_AW-1:0] A_DEPTH = 3'd6;
  localparam logic [REG_AW-1:0] A_WIDTH = 3'd7;
endpackage

// File: rtl/trc_hold.sv
module trc_hold #(
  parameter int WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             trig_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] word_o,
  output logic             trig_o
);
  logic             vld_q;
  logic [WIDTH-1:0] word_q;
  logic             trig_q;

  // drains every cycle: consumed or dropped by the controller
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      word_q <= '0;
      trig_q <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (load_i) begin
        word_q <= word_i;
        trig_q <= trig_i;
      end
    end
  end

  assign vld_o  = vld_q;
  assign word_o = word_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read-before-write on address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/trc_ctl.sv
module trc_ctl
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic              hold_vld_i,
  input  logic              hold_trig_i,
  output logic              cap_on_o,
  output logic              ram_we_o,
  output logic [AW-1:0]     wptr_o,
  output logic              ram_re_o,
  output logic [AW-1:0]     rptr_o,
  output logic [REG_DW-1:0] rdata_o,
  output logic              sel_ram_o
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic en_q, demux_q, full_q, trig_q, done_q;
  logic [AW-1:0] wptr_q, rptr_q;
  logic [REG_DW-1:0] tcnt_q;
  logic [REG_DW-1:0] rdata_q;
  logic sel_ram_q;

  logic wr_ctrl, wr_wptr, wr_rptr, wr_tcnt, rd_ram, en_rise, fire;
  logic [AW-1:0] wptr_inc, rptr_inc;
  logic [REG_DW-1:0] rd_mux;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_wptr  = reg_we_i && (reg_addr_i == A_WPTR);
  assign wr_rptr  = reg_we_i && (reg_addr_i == A_RPTR);
  assign wr_tcnt  = reg_we_i && (reg_addr_i == A_TCNT);
  assign rd_ram   = reg_re_i && (reg_addr_i == A_RDATA);
  assign en_rise  = wr_ctrl && reg_wdata_i[0] && !en_q;
  assign cap_on_o = en_q && !done_q;
  assign fire     = hold_vld_i && cap_on_o;
  assign wptr_inc = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
  assign rptr_inc = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      demux_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q    <= reg_wdata_i[0];
      demux_q <= reg_wdata_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      full_q <= 1'b0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_wptr)   wptr_q <= reg_wdata_i[AW-1:0];
      else if (fire) wptr_q <= wptr_inc;

      if (en_rise) begin
        full_q <= 1'b0;
        trig_q <= 1'b0;
        done_q <= 1'b0;
      end else if (fire) begin
        if (wptr_q == PTR_LAST)          full_q <= 1'b1;
        if (hold_trig_i)                 trig_q <= 1'b1;
        if (trig_q && tcnt_q <= 32'd1)   done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           tcnt_q <= '0;
    else if (wr_tcnt)                      tcnt_q <= reg_wdata_i;
    else if (fire && trig_q && tcnt_q != '0) tcnt_q <= tcnt_q - 32'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rptr_q <= '0;
    else if (wr_rptr) rptr_q <= reg_wdata_i[AW-1:0];
    else if (rd_ram)  rptr_q <= rptr_inc;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  rd_mux = {30'b0, demux_q, en_q};
      A_STAT:  rd_mux = {28'b0, !hold_vld_i, done_q, trig_q, full_q};
      A_WPTR:  rd_mux = REG_DW'(wptr_q);
      A_RPTR:  rd_mux = REG_DW'(rptr_q);
      A_TCNT:  rd_mux = tcnt_q;
      A_DEPTH: rd_mux = REG_DW'(DEPTH);
      A_WIDTH: rd_mux = REG_DW'(WIDTH);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      sel_ram_q <= 1'b0;
    end else if (reg_re_i) begin
      rdata_q   <= rd_mux;
      sel_ram_q <= rd_ram;
    end
  end

  assign ram_we_o  = fire;
  assign wptr_o    = wptr_q;
  assign ram_re_o  = rd_ram;
  assign rptr_o    = rptr_q;
  assign rdata_o   = rdata_q;
  assign sel_ram_o = sel_ram_q;

  assert_full_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !en_rise) |=> full_q);

  assert_trig_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !en_rise) |=> trig_q);

  assert_done_has_trig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> trig_q);

  assert_frozen_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !wr_wptr) |=> $stable(wptr_q));

  assert_rptr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ram && !wr_rptr) |=>
      (rptr_q == (($past(rptr_q) == PTR_LAST) ? '0 : $past(rptr_q) + 1'b1)));
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trace_valid_i,
  input  logic [WIDTH-1:0]  trace_word_i,
  input  logic              trace_trig_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [REG_DW-1:0] reg_rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic             cap_on, hold_vld, hold_trig, ram_we, ram_re, sel_ram;
  logic [WIDTH-1:0] hold_word, ram_q;
  logic [AW-1:0]    wptr, rptr;
  logic [REG_DW-1:0] ctl_rdata;

  trc_hold #(.WIDTH(WIDTH)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (trace_valid_i && cap_on),
    .word_i (trace_word_i),
    .trig_i (trace_trig_i),
    .vld_o  (hold_vld),
    .word_o (hold_word),
    .trig_o (hold_trig)
  );

  trc_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_we_i    (reg_we_i),
    .reg_re_i    (reg_re_i),
    .hold_vld_i  (hold_vld),
    .hold_trig_i (hold_trig),
    .cap_on_o    (cap_on),
    .ram_we_o    (ram_we),
    .wptr_o      (wptr),
    .ram_re_o    (ram_re),
    .rptr_o      (rptr),
    .rdata_o     (ctl_rdata),
    .sel_ram_o   (sel_ram)
  );

  trc_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we),
    .waddr_i (wptr),
    .wdata_i (hold_word),
    .re_i    (ram_re),
    .raddr_i (rptr),
    .rdata_o (ram_q)
  );

  assign reg_rdata_o = sel_ram ? REG_DW'(ram_q) : ctl_rdata;

  assert_hold_origin_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_vld |-> $past(trace_valid_i));
endmodule

// File: tb/trace_capture_buf_bench.sv
module trace_capture_buf_bench;
  import trc_pkg::*;

  localparam int DEPTH = 16;
  localparam int WIDTH = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              trace_valid_i = 1'b0;
  logic [WIDTH-1:0]  trace_word_i = '0;
  logic              trace_trig_i = 1'b0;
  logic [REG_AW-1:0] reg_addr_i = '0;
  logic [REG_DW-1:0] reg_wdata_i = '0;
  logic              reg_we_i = 1'b0;
  logic              reg_re_i = 1'b0;
  logic [REG_DW-1:0] reg_rdata_o;

  always #10 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_trace_capture_buf (
    .clk_i(clk), .rst_ni(rst_ni), .trace_valid_i(trace_valid_i),
    .trace_word_i(trace_word_i), .trace_trig_i(trace_trig_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_we_i(reg_we_i),
    .reg_re_i(reg_re_i), .reg_rdata_o(reg_rdata_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [WIDTH-1:0] model [DEPTH];
  int mwp = 0;
  logic [REG_DW-1:0] v;

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_CTRL,  32'd0, 32'd0, 8'd1},          // R1
    '{1'b0, A_STAT,  32'd0, 32'h8, 8'd1},          // R1
    '{1'b0, A_WPTR,  32'd0, 32'd0, 8'd1},          // R1
    '{1'b0, A_TCNT,  32'd0, 32'd0, 8'd1},          // R1
    '{1'b0, A_DEPTH, 32'd0, 32'd16, 8'd12},        // R12
    '{1'b0, A_WIDTH, 32'd0, 32'd16, 8'd12},        // R12
    '{1'b1, A_WPTR,  32'd5, 32'd0, 8'd7},
    '{1'b0, A_WPTR,  32'd0, 32'd5, 8'd7},          // R7
    '{1'b1, A_RPTR,  32'd9, 32'd0, 8'd7},
    '{1'b0, A_RPTR,  32'd0, 32'd9, 8'd7},          // R7
    '{1'b1, A_TCNT,  32'h10007, 32'd0, 8'd7},
    '{1'b0, A_TCNT,  32'd0, 32'h10007, 8'd7},      // R7
    '{1'b1, A_DEPTH, 32'd3, 32'd0, 8'd12},
    '{1'b0, A_DEPTH, 32'd0, 32'd16, 8'd12},        // R12
    '{1'b1, A_STAT,  32'd7, 32'd0, 8'd12},
    '{1'b0, A_STAT,  32'd0, 32'h8, 8'd12},         // R12
    '{1'b1, A_CTRL,  32'd2, 32'd0, 8'd2},
    '{1'b0, A_CTRL,  32'd0, 32'd2, 8'd2},          // R2
    '{1'b1, A_CTRL,  32'd0, 32'd0, 8'd2},
    '{1'b1, A_WPTR,  32'd0, 32'd0, 8'd7},
    '{1'b1, A_RPTR,  32'd0, 32'd0, 8'd7},
    '{1'b1, A_TCNT,  32'd0, 32'd0, 8'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_re_i = 1'b1;
    @(negedge clk);
    reg_re_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_rd(a, d);
    check(req, d, exp);
  endtask

  // store=1: the word is expected to land in RAM
  task automatic push(input logic [WIDTH-1:0] w, input logic t, input bit store);
    @(negedge clk);
    trace_valid_i = 1'b1; trace_word_i = w; trace_trig_i = t;
    @(negedge clk);
    trace_valid_i = 1'b0; trace_trig_i = 1'b0;
    if (store) begin
      model[mwp] = w;
      mwp = (mwp + 1) % DEPTH;
    end
  endtask

  task automatic burst(input int n, input logic [WIDTH-1:0] base, input bit store);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trace_valid_i = 1'b1; trace_word_i = base + WIDTH'(i); trace_trig_i = 1'b0;
      if (store) begin
        model[mwp] = base + WIDTH'(i);
        mwp = (mwp + 1) % DEPTH;
      end
    end
    @(negedge clk);
    trace_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) reg_wr(VEC[i].addr, VEC[i].data);
      else begin
        reg_rd(VEC[i].addr, v);
        check($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].exp);
      end
    end

    // basic capture and readback
    mwp = 0;
    reg_wr(A_TCNT, 32'd4);
    reg_wr(A_CTRL, 32'd1);
    push(16'hA000, 1'b0, 1);
    push(16'hA001, 1'b0, 1);
    push(16'hA002, 1'b0, 1);
    rd_chk("R3 wptr after 3", A_WPTR, 32'd3);
    rd_chk("R3 no full", A_STAT, 32'h0000_0008);
    rd_chk("R8 data0", A_RDATA, 32'hA000);
    rd_chk("R8 data1", A_RDATA, 32'hA001);
    rd_chk("R8 data2", A_RDATA, 32'hA002);
    rd_chk("R8 rptr advanced", A_RPTR, 32'd3);
    reg_wr(A_RDATA, 32'h55);
    rd_chk("R12 rdata write ignored", A_RPTR, 32'd3);

    // FormatterEmpty low in the cycle after acceptance (R9)
    @(negedge clk);
    trace_valid_i = 1'b1; trace_word_i = 16'hA003;
    @(negedge clk);
    trace_valid_i = 1'b0; reg_addr_i = A_STAT; reg_re_i = 1'b1;
    @(negedge clk);
    reg_re_i = 1'b0;
    check("R9 pending word", reg_rdata_o, 32'h0);
    model[mwp] = 16'hA003; mwp = mwp + 1;
    rd_chk("R9 drained", A_STAT, 32'h8);

    // wrap and full (R3)
    burst(12, 16'hB004, 1);
    rd_chk("R3 full set", A_STAT, 32'h9);
    rd_chk("R3 wptr wrapped", A_WPTR, 32'd0);
    push(16'hC000, 1'b0, 1);
    reg_wr(A_RPTR, 32'd1);
    rd_chk("R8 oldest at wptr", A_RDATA, {16'h0, model[1]});
    reg_wr(A_RPTR, 32'd15);
    rd_chk("R8 last slot", A_RDATA, {16'h0, model[15]});
    rd_chk("R8 rptr wrap data", A_RDATA, 32'hC000);
    rd_chk("R8 rptr wrapped", A_RPTR, 32'd1);

    // trigger, countdown, completion
    reg_wr(A_CTRL, 32'd0);
    reg_wr(A_CTRL, 32'd1);
    rd_chk("R10 flags cleared", A_STAT, 32'h8);
    reg_wr(A_WPTR, 32'd0); mwp = 0;
    reg_wr(A_TCNT, 32'd3);
    push(16'hD000, 1'b0, 1);
    push(16'hD001, 1'b0, 1);
    push(16'hD002, 1'b1, 1);
    rd_chk("R4 triggered", A_STAT, 32'hA);
    rd_chk("R5 trigger word not counted", A_TCNT, 32'd3);
    push(16'hD003, 1'b0, 1);
    push(16'hD004, 1'b0, 1);
    rd_chk("R5 count 1", A_TCNT, 32'd1);
    rd_chk("R5 not done", A_STAT, 32'hA);
    push(16'hD005, 1'b0, 1);
    rd_chk("R5 done", A_STAT, 32'hE);
    rd_chk("R5 count 0", A_TCNT, 32'd0);
    burst(3, 16'hEE00, 0);
    rd_chk("R6 wptr frozen", A_WPTR, 32'd6);
    reg_wr(A_RPTR, 32'd5);
    rd_chk("R6 last stored word", A_RDATA, 32'hD005);
    rd_chk("R6 slot after untouched", A_RDATA, {16'h0, model[6]});

    // disable / re-enable
    reg_wr(A_CTRL, 32'd0);
    rd_chk("R11 flags kept", A_STAT, 32'hE);
    rd_chk("R11 wptr kept", A_WPTR, 32'd6);
    reg_wr(A_CTRL, 32'd1);
    rd_chk("R10 cleared on enable", A_STAT, 32'h8);
    rd_chk("R11 wptr kept on enable", A_WPTR, 32'd6);
    push(16'hE000, 1'b0, 1);
    rd_chk("R13 accepted when on", A_WPTR, 32'd7);
    reg_wr(A_CTRL, 32'd0);
    push(16'hE001, 1'b0, 0);
    rd_chk("R11 no store when off", A_WPTR, 32'd7);
    reg_wr(A_CTRL, 32'd1);
    push(16'hF000, 1'b1, 1);
    rd_chk("R4 trigger again", A_STAT, 32'hA);
    reg_wr(A_CTRL, 32'd3);
    rd_chk("R10 no clear while on", A_STAT, 32'hA);
    rd_chk("R2 ctrl readback", A_CTRL, 32'd3);
    push(16'hF001, 1'b0, 1);
    rd_chk("R5 zero count acts as one", A_STAT, 32'hE);

    // reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    rd_chk("R1 ctrl after reset", A_CTRL, 32'd0);
    rd_chk("R1 stat after reset", A_STAT, 32'h8);
    rd_chk("R1 wptr after reset", A_WPTR, 32'd0);
    rd_chk("R1 rptr after reset", A_RPTR, 32'd0);

    finish_run();
  end
endmodule